// File: doc/BRIEF.md
# Data memory address modifier

This block keeps four 4-bit system registers that steer data memory addressing: a high, a middle and a low index nibble, and a status nibble. From them it forms the effective data memory address for two operand styles. A direct operand (a 7-bit address of 3 row bits above 4 column bits) can have the middle and low index nibbles ORed into it, while the low three bits of the high nibble are ORed into the current bank. A register-indirect operand can have its bank and row replaced by a pointer formed from the high and middle nibbles, while the column always comes from the contents of the addressed general register.

The high and middle nibbles serve both as index bits and as pointer bits, so a single write updates both views. Each mode has its own enable: index mode is enabled by bit 0 of the status nibble and pointer mode by bit 3 of the high nibble. A build parameter restricts the block to bank 0 by holding every bank-select storage bit at zero. The effective address outputs follow the register state and the operands combinationally. Register writes take effect on the next clock edge.

Top module: `dmam_top`

## Requirements
- R1: After a synchronous reset every register reads back 0, and a read of any address then returns 0.
- R2: Register addresses are 7'h7A (high), 7'h7B (middle), 7'h7C (low) and 7'h7F (status). Each returns the written nibble on `sr_rdata` when addressed. Any other address reads 0, and a write to it changes no register and no output.
- R3: A write becomes visible only after the next rising clock edge. Without a write the read data for an unchanged address stays constant.
- R4: The index enable is bit 0 of the status nibble. When it is 0, the direct bank equals `cur_bank` and the direct address equals `dir_addr`.
- R5: When the index enable is 1, the direct address is `dir_addr` ORed with {middle[2:0], low[3:0]}, truncated to 7 bits. The direct bank is `cur_bank` ORed with {1'b0, high[2:0]}.
- R6: The pointer enable is bit 3 of the high nibble. When it is 0, the indirect bank is `cur_bank` and the indirect row is `ind_row`.
- R7: When the pointer enable is 1, the indirect bank is {high[2:0], middle[3]} and the indirect row is middle[2:0].
- R8: The indirect column equals `ind_col` whatever the state of the pointer enable.
- R9: With RESTRICT_BANK=1, high[2:0] and middle[3] are held at 0 and read back as 0. The direct bank is always `cur_bank`, and the indirect bank is 0 whenever the pointer enable is 1.
- R10: A single write to 7'h7A or 7'h7B changes both the index result and the pointer result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sr_we | input | 1 | Register write strobe |
| sr_addr | input | 7 | Register address for read and write |
| sr_wdata | input | 4 | Write data nibble |
| sr_rdata | output | 4 | Read data nibble of the addressed register |
| cur_bank | input | 4 | Current data memory bank |
| dir_addr | input | 7 | Direct operand address {row[2:0], col[3:0]} |
| ind_row | input | 3 | Row part of the register-indirect operand |
| ind_col | input | 4 | Contents of the addressed general register (column) |
| dir_bank_o | output | 4 | Effective bank for a direct access |
| dir_addr_o | output | 7 | Effective address for a direct access |
| ind_bank_o | output | 4 | Effective bank for an indirect access |
| ind_row_o | output | 3 | Effective row for an indirect access |
| ind_col_o | output | 4 | Effective column for an indirect access |

## Verification
On every cycle the assertions check several relations. The indirect column passes through unchanged. The index OR never clears an operand or bank bit. Reset leaves all read data at zero. Read data holds while nothing is written. In the restricted build, no bank other than the current one or bank 0 can appear. The exact OR values, the pointer substitution, the shared-address effect on both modes and the masking of stored bank bits can only be shown by the bench. It sweeps all high and middle nibble values, both enable states and every direct operand, with both the full and the restricted build side by side.

// File: rtl/dmam_pkg.sv
package dmam_pkg;

    localparam int REG_W   = 4;
    localparam int SR_AW   = 7;
    localparam int ROW_W   = 3;
    localparam int COL_W   = 4;
    localparam int BANK_W  = 4;
    localparam int DADDR_W = ROW_W + COL_W;

    localparam logic [SR_AW-1:0] SR_HI  = 7'h7A;
    localparam logic [SR_AW-1:0] SR_MID = 7'h7B;
    localparam logic [SR_AW-1:0] SR_LO  = 7'h7C;
    localparam logic [SR_AW-1:0] SR_PSW = 7'h7F;

    typedef struct packed {
        logic [REG_W-1:0] hi;
        logic [REG_W-1:0] mid;
        logic [REG_W-1:0] lo;
        logic [REG_W-1:0] psw;
    } mod_regs_t;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
    } dm_loc_t;

    function automatic logic ix_on(mod_regs_t r);
        return r.psw[0];
    endfunction

    function automatic logic mp_on(mod_regs_t r);
        return r.hi[REG_W-1];
    endfunction

    // bits of each register that may hold a one
    function automatic logic [REG_W-1:0] keep_mask(logic restrict_bank,
                                                    logic [SR_AW-1:0] a);
        logic [REG_W-1:0] m;
        m = '1;
        if (restrict_bank) begin
            if (a == SR_HI)  m = 4'b1000;
            if (a == SR_MID) m = 4'b0111;
        end
        return m;
    endfunction

endpackage

// File: rtl/dmam_regfile.sv
module dmam_regfile
    import dmam_pkg::*;
#(
    parameter bit RESTRICT_BANK = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [SR_AW-1:0] addr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output mod_regs_t        regs
);

    logic [REG_W-1:0] wval;

    assign wval = wdata & keep_mask(RESTRICT_BANK, addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else if (we) begin
            case (addr)
                SR_HI:   regs.hi  <= wval;
                SR_MID:  regs.mid <= wval;
                SR_LO:   regs.lo  <= wval;
                SR_PSW:  regs.psw <= wval;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            SR_HI:   rdata = regs.hi;
            SR_MID:  rdata = regs.mid;
            SR_LO:   rdata = regs.lo;
            SR_PSW:  rdata = regs.psw;
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/dmam_direct.sv
module dmam_direct
    import dmam_pkg::*;
#(
    parameter bit RESTRICT_BANK = 1'b0
) (
    input  mod_regs_t           regs,
    input  logic [BANK_W-1:0]   cur_bank,
    input  logic [DADDR_W-1:0]  op_addr,
    output logic [BANK_W-1:0]   eff_bank,
    output logic [DADDR_W-1:0]  eff_addr
);

    logic [2*REG_W-1:0] ix_low;

    assign ix_low = {regs.mid, regs.lo};

    always_comb begin
        eff_addr = op_addr;
        if (ix_on(regs)) begin
            eff_addr = op_addr | ix_low[DADDR_W-1:0];
        end
    end

    if (RESTRICT_BANK) begin : g_fixed_bank
        assign eff_bank = cur_bank;
    end else begin : g_or_bank
        always_comb begin
            eff_bank = cur_bank;
            if (ix_on(regs)) begin
                eff_bank = cur_bank | {1'b0, regs.hi[REG_W-2:0]};
            end
        end
    end

endmodule

// File: rtl/dmam_indirect.sv
module dmam_indirect
    import dmam_pkg::*;
#(
    parameter bit RESTRICT_BANK = 1'b0
) (
    input  mod_regs_t          regs,
    input  logic [BANK_W-1:0]  cur_bank,
    input  logic [ROW_W-1:0]   op_row,
    input  logic [COL_W-1:0]   reg_col,
    output dm_loc_t            loc
);

    logic [BANK_W-1:0] ptr_bank;

    if (RESTRICT_BANK) begin : g_bank0
        assign ptr_bank = '0;
    end else begin : g_ptr_bank
        assign ptr_bank = {regs.hi[REG_W-2:0], regs.mid[REG_W-1]};
    end

    always_comb begin
        loc.col = reg_col;
        if (mp_on(regs)) begin
            loc.bank = ptr_bank;
            loc.row  = regs.mid[ROW_W-1:0];
        end else begin
            loc.bank = cur_bank;
            loc.row  = op_row;
        end
    end

endmodule

// File: rtl/dmam_top.sv
module dmam_top
    import dmam_pkg::*;
#(
    parameter bit RESTRICT_BANK = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sr_we,
    input  logic [SR_AW-1:0]   sr_addr,
    input  logic [REG_W-1:0]   sr_wdata,
    output logic [REG_W-1:0]   sr_rdata,
    input  logic [BANK_W-1:0]  cur_bank,
    input  logic [DADDR_W-1:0] dir_addr,
    input  logic [ROW_W-1:0]   ind_row,
    input  logic [COL_W-1:0]   ind_col,
    output logic [BANK_W-1:0]  dir_bank_o,
    output logic [DADDR_W-1:0] dir_addr_o,
    output logic [BANK_W-1:0]  ind_bank_o,
    output logic [ROW_W-1:0]   ind_row_o,
    output logic [COL_W-1:0]   ind_col_o
);

    mod_regs_t regs;
    dm_loc_t   ind_loc;

    dmam_regfile #(.RESTRICT_BANK(RESTRICT_BANK)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (sr_we),
        .addr  (sr_addr),
        .wdata (sr_wdata),
        .rdata (sr_rdata),
        .regs  (regs)
    );

    dmam_direct #(.RESTRICT_BANK(RESTRICT_BANK)) u_dir (
        .regs     (regs),
        .cur_bank (cur_bank),
        .op_addr  (dir_addr),
        .eff_bank (dir_bank_o),
        .eff_addr (dir_addr_o)
    );

    dmam_indirect #(.RESTRICT_BANK(RESTRICT_BANK)) u_ind (
        .regs     (regs),
        .cur_bank (cur_bank),
        .op_row   (ind_row),
        .reg_col  (ind_col),
        .loc      (ind_loc)
    );

    assign ind_bank_o = ind_loc.bank;
    assign ind_row_o  = ind_loc.row;
    assign ind_col_o  = ind_loc.col;

endmodule

// File: rtl/dmam_checker.sv
module dmam_checker
    import dmam_pkg::*;
#(
    parameter bit RESTRICT_BANK = 1'b0
) (
    input logic               clk,
    input logic               rst,
    input logic               sr_we,
    input logic [SR_AW-1:0]   sr_addr,
    input logic [REG_W-1:0]   sr_rdata,
    input logic [BANK_W-1:0]  cur_bank,
    input logic [DADDR_W-1:0] dir_addr,
    input logic [COL_W-1:0]   ind_col,
    input logic [BANK_W-1:0]  dir_bank_o,
    input logic [DADDR_W-1:0] dir_addr_o,
    input logic [BANK_W-1:0]  ind_bank_o,
    input logic [COL_W-1:0]   ind_col_o
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        ($past(rst) && !rst) |-> (sr_rdata == '0)); // R1

    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(sr_we) && $stable(sr_addr)) |-> $stable(sr_rdata)); // R3

    AST_OR_KEEPS_ADDR: assert property (@(posedge clk) disable iff (rst)
        (dir_addr_o & dir_addr) == dir_addr); // R5

    AST_OR_KEEPS_BANK: assert property (@(posedge clk) disable iff (rst)
        (dir_bank_o & cur_bank) == cur_bank); // R5

    AST_COL_FROM_REG: assert property (@(posedge clk) disable iff (rst)
        ind_col_o == ind_col); // R8

    AST_RESTRICT_DIR: assert property (@(posedge clk) disable iff (rst)
        RESTRICT_BANK |-> (dir_bank_o == cur_bank)); // R9

    AST_RESTRICT_IND: assert property (@(posedge clk) disable iff (rst)
        RESTRICT_BANK |-> (ind_bank_o == '0 || ind_bank_o == cur_bank)); // R9

endmodule

bind dmam_top dmam_checker #(.RESTRICT_BANK(RESTRICT_BANK)) chk_i (.*);

// File: tb/dmam_tb_top.sv
`timescale 1ns/1ps
module dmam_top_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sr_we = 1'b0;
    logic [6:0] sr_addr = '0;
    logic [3:0] sr_wdata = '0;
    logic [3:0] cur_bank = '0;
    logic [6:0] dir_addr = '0;
    logic [2:0] ind_row = '0;
    logic [3:0] ind_col = '0;

    logic [3:0] rd_f, db_f, ib_f, ic_f, rd_r, db_r, ib_r, ic_r;
    logic [6:0] da_f, da_r;
    logic [2:0] ir_f, ir_r;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    dmam_top #(.RESTRICT_BANK(1'b0)) dut_i (
        .clk(clk), .rst(rst), .sr_we(sr_we), .sr_addr(sr_addr),
        .sr_wdata(sr_wdata), .sr_rdata(rd_f), .cur_bank(cur_bank),
        .dir_addr(dir_addr), .ind_row(ind_row), .ind_col(ind_col),
        .dir_bank_o(db_f), .dir_addr_o(da_f), .ind_bank_o(ib_f),
        .ind_row_o(ir_f), .ind_col_o(ic_f)
    );

    dmam_top #(.RESTRICT_BANK(1'b1)) dut_r (
        .clk(clk), .rst(rst), .sr_we(sr_we), .sr_addr(sr_addr),
        .sr_wdata(sr_wdata), .sr_rdata(rd_r), .cur_bank(cur_bank),
        .dir_addr(dir_addr), .ind_row(ind_row), .ind_col(ind_col),
        .dir_bank_o(db_r), .dir_addr_o(da_r), .ind_bank_o(ib_r),
        .ind_row_o(ir_r), .ind_col_o(ic_r)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] rmask(input logic [6:0] a);
        if (a == 7'h7A) return 4'h8;
        if (a == 7'h7B) return 4'h7;
        return 4'hF;
    endfunction

    task automatic wr(input logic [6:0] a, input logic [3:0] d);
        @(negedge clk);
        sr_we = 1'b1; sr_addr = a; sr_wdata = d;
        @(negedge clk);
        sr_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [6:0] a,
                          input logic [3:0] ef, input logic [3:0] er);
        sr_addr = a;
        #1;
        chk(req, rd_f, ef);
        chk(req, rd_r, er);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    initial begin
        logic [6:0] addrs [4];
        addrs = '{7'h7A, 7'h7B, 7'h7C, 7'h7F};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        foreach (addrs[k]) rd_chk("R1", addrs[k], 4'h0, 4'h0);
        // R4/R6/R8: both enables off after reset
        cur_bank = 4'h5; dir_addr = 7'h2C; ind_row = 3'h6; ind_col = 4'h9;
        #1;
        chk("R4", {4'h0, db_f}, 8'h05); chk("R4", {1'b0, da_f}, 8'h2C);
        chk("R6", {4'h0, ib_f}, 8'h05); chk("R6", {5'h0, ir_f}, 8'h06);
        chk("R8", {4'h0, ic_f}, 8'h09);

        // R2: full write/readback sweep on each register
        foreach (addrs[k]) begin
            for (int v = 0; v < 16; v++) begin
                wr(addrs[k], 4'(v));
                rd_chk("R2", addrs[k], 4'(v), 4'(v) & rmask(addrs[k]));
            end
        end
        // R2: unmapped address ignored
        wr(7'h7A, 4'h3); wr(7'h7B, 4'hA); wr(7'h7C, 4'h5); wr(7'h7F, 4'h1);
        cur_bank = 4'h0; dir_addr = 7'h00; #1;
        chk("R2", {1'b0, da_f}, 8'h25);
        wr(7'h10, 4'hF); wr(7'h7D, 4'hF);
        rd_chk("R2", 7'h10, 4'h0, 4'h0);
        rd_chk("R2", 7'h7D, 4'h0, 4'h0);
        rd_chk("R2", 7'h7A, 4'h3, 4'h0);
        rd_chk("R2", 7'h7C, 4'h5, 4'h5);
        chk("R2", {1'b0, da_f}, 8'h25);

        // R3: write visible only after the edge
        @(negedge clk);
        sr_we = 1'b1; sr_addr = 7'h7C; sr_wdata = 4'hC;
        #1;
        chk("R3", {4'h0, rd_f}, 8'h05);
        @(negedge clk);
        sr_we = 1'b0; #1;
        chk("R3", {4'h0, rd_f}, 8'h0C);

        // R10: one write to 7A changes both modes
        wr(7'h7F, 4'h1); wr(7'h7B, 4'h0); wr(7'h7A, 4'hD);
        cur_bank = 4'h0; ind_row = 3'h1; #1;
        chk("R10", {4'h0, db_f}, 8'h05);
        chk("R10", {4'h0, ib_f}, 8'h0A);

        // R4..R9: sweep high/mid nibbles, index enable, operands
        for (int h = 0; h < 16; h++) begin
            for (int m = 0; m < 16; m++) begin
                for (int p = 0; p < 2; p++) begin
                    logic [3:0] hv, mv, lv, pv;
                    hv = 4'(h); mv = 4'(m);
                    lv = (m[0]) ? 4'h9 : 4'h6;
                    pv = p[0] ? 4'h1 : 4'hE;
                    wr(7'h7A, hv); wr(7'h7B, mv); wr(7'h7C, lv); wr(7'h7F, pv);
                    for (int op = 0; op < 128; op++) begin
                        logic [3:0] cb, ebf, eib, eibr;
                        logic [6:0] ea;
                        logic [2:0] eir;
                        cb = 4'(op * 5 + h);
                        cur_bank = cb; dir_addr = 7'(op);
                        ind_row = 3'(op >> 4); ind_col = 4'(op) ^ 4'hA;
                        #1;
                        ea  = pv[0] ? (7'(op) | {mv[2:0], lv}) : 7'(op);
                        ebf = pv[0] ? (cb | {1'b0, hv[2:0]}) : cb;
                        eib = hv[3] ? {hv[2:0], mv[3]} : cb;
                        eibr = hv[3] ? 4'h0 : cb;
                        eir = hv[3] ? mv[2:0] : 3'(op >> 4);
                        if (pv[0]) begin
                            chk("R5", {1'b0, da_f}, {1'b0, ea});
                            chk("R5", {4'h0, db_f}, {4'h0, ebf});
                        end else begin
                            chk("R4", {1'b0, da_f}, {1'b0, ea});
                            chk("R4", {4'h0, db_f}, {4'h0, ebf});
                        end
                        if (hv[3]) begin
                            chk("R7", {4'h0, ib_f}, {4'h0, eib});
                            chk("R7", {5'h0, ir_f}, {5'h0, eir});
                        end else begin
                            chk("R6", {4'h0, ib_f}, {4'h0, eib});
                            chk("R6", {5'h0, ir_f}, {5'h0, eir});
                        end
                        chk("R8", {4'h0, ic_f}, {4'h0, 4'(op) ^ 4'hA});
                        chk("R9", {1'b0, da_r}, {1'b0, ea});
                        chk("R9", {4'h0, db_r}, {4'h0, cb});
                        chk("R9", {4'h0, ib_r}, {4'h0, eibr});
                        chk("R9", {5'h0, ir_r}, {5'h0, eir});
                        chk("R8", {4'h0, ic_r}, {4'h0, 4'(op) ^ 4'hA});
                    end
                end
            end
        end
        summary();
    end

endmodule